// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the transaction layer of an SMBus host controller. Software fills a small byte-wide register file with a target address, a command byte and up to two data bytes. It then writes a control byte that names the protocol and carries a start bit. The sequencer breaks the transaction into byte operations (start condition, byte write, byte read with acknowledge, byte read without acknowledge, stop condition). It hands these one at a time to a byte-level bus engine, which is not part of this block and answers each one with a done pulse.

Results come back in a status register. Its flags are cleared by writing a one to them. A missing acknowledge and a lost arbitration are reported as separate errors. A kill bit in the control byte aborts a transaction that is in flight. Read results land in the two data registers. The transaction-complete flag drives an interrupt output.

The supported protocols are quick command, send/receive byte, byte data and word data, each in both directions.

Top module: `smb_host`

## Requirements
- R1: After reset the status, control and data registers read 0x00, `irq` is low and no byte operation is requested (`op_valid` low).
- R2: The register offsets are: status 0, control 2, command 3, address 4, data0 5, data1 6. Control reads back its bits 7 and 4:1 and reads bit 6 as 0. Any other offset reads 0x00.
- R3: The protocol field is control bits 4:2: quick 0x00, byte 0x04, byte-data 0x08, word-data 0x0C. Writing control with bit 6 (0x40) set starts a transaction. The address register holds the 7-bit target in bits 7:1 and the direction in bit 0 (1 = read). A write issues start, the address byte, then the command byte (except for quick), then data0 and, for word transfers, data1, then stop. Byte operation codes are: 0 start, 1 write byte, 2 read with ACK, 3 read with NACK, 4 stop.
- R4: A byte-data or word-data read issues start, the address with bit 0 cleared, the command, a repeated start, and the address with bit 0 set. It then reads the data bytes, all but the last with ACK and the last with NACK, then stop. A receive-byte read issues start, the address byte, one NACK read, then stop.
- R5: A word read stores the first (low) byte in data0 and the second (high) byte in data1. A byte or byte-data read stores its byte in data0.
- R6: On a successful transaction, busy (status 0x01) clears and the interrupt flag (status 0x02) sets in the same cycle. `irq` follows the interrupt flag.
- R7: A NACK on any written byte makes the next operation a stop. When that stop completes, busy clears and the device-error flag (0x04) sets. The interrupt flag is not set.
- R8: Lost arbitration on any operation ends the transaction at once, with no stop. Busy clears and the bus-error flag (0x08) sets. The interrupt flag is not set.
- R9: Setting kill (control bit 0x02) while busy clears busy and sets the failed flag (0x10) one cycle after the write.
- R10: A start written while busy is ignored. The stored protocol field does not change and no extra transaction runs.
- R11: Writing 1 to a status flag clears only that flag. Busy is not affected by status writes. A flag set by the engine in the same cycle as a clear stays set.
- R12: A start with an unsupported protocol field (bit 4 set, such as 0x14) issues no byte operation and sets the failed flag.
- R13: Busy reads 1 in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Transaction-complete interrupt |
| op_valid | output | 1 | Byte operation requested, held until op_done |
| op_code | output | 3 | Byte operation code |
| op_wdata | output | 8 | Byte to send for a write operation |
| op_done | input | 1 | One-cycle completion pulse from the byte engine |
| op_nack | input | 1 | Written byte was not acknowledged (with op_done) |
| op_arb_lost | input | 1 | Arbitration lost (with op_done) |
| op_rdata | input | 8 | Byte received (with op_done) |

## Verification
The checker watches a number of cycle-level rules on every clock:
- a NACK on a written byte is followed directly by a stop request;
- a lost arbitration ends busy and sets the bus-error flag on the next cycle;
- a kill ends busy with the failed flag one cycle later;
- a clean stop raises `irq` as busy falls, while an aborted stop sets device error without raising `irq`;
- a start accepted while idle sets busy;
- a control write during busy leaves the protocol field untouched.

Other behaviour shows only in the bench's scenarios:
- the exact order and contents of the byte operations for each protocol and direction;
- where read bytes land in the data registers;
- the selectivity of write-one-to-clear;
- the register readback map;
- the absence of any bus activity for an unsupported protocol.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  localparam int BYTE_W = 8;
  localparam int FLAG_N = 4;

  // register offsets
  localparam int OFS_STATUS = 0;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_BYTE0  = 3;  // command, address, data0, data1 follow
  localparam int NUM_BYTE_REGS = 4;

  // flag indices (status bit = index + 1)
  localparam int F_INTR = 0;
  localparam int F_DEV  = 1;
  localparam int F_BUS  = 2;
  localparam int F_FAIL = 3;

  // control bits kept in storage: pec(7), protocol(4:2), kill(1)
  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'h9E;
  localparam int CTRL_START_BIT = 6;
  localparam int CTRL_KILL_BIT  = 1;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_WRITE   = 3'd1,
    OP_RD_ACK  = 3'd2,
    OP_RD_NACK = 3'd3,
    OP_STOP    = 3'd4
  } bus_op_e;

  typedef enum logic [2:0] {
    PR_QUICK = 3'd0,
    PR_BYTE  = 3'd1,
    PR_BDATA = 3'd2,
    PR_WORD  = 3'd3
  } proto_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_START, SQ_ADDR, SQ_CMD, SQ_RSTART,
    SQ_ADDR2, SQ_D0, SQ_D1, SQ_STOP
  } seq_state_e;

  typedef struct packed {
    logic ok;
    logic nack;
    logic arb;
    logic killed;
    logic badproto;
  } seq_evt_t;

endpackage

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              busy,
  input  seq_evt_t          evt,
  input  logic              cap0_en,
  input  logic              cap1_en,
  input  logic [BYTE_W-1:0] cap_data,
  output logic              start_req,
  output logic              start_bad,
  output logic              kill,
  output logic [2:0]        proto,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] addr_q,
  output logic [BYTE_W-1:0] data0_q,
  output logic [BYTE_W-1:0] data1_q,
  output logic [FLAG_N-1:0] flags
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

  logic              sel_status, sel_ctrl;
  logic [FLAG_N-1:0] flag_q, flag_d, flag_set, flag_clr;
  logic              flag_en;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] breg_q [NUM_BYTE_REGS];

  assign sel_status = host_wr && (host_addr == A_STATUS);
  assign sel_ctrl   = host_wr && (host_addr == A_CTRL);

  // status flags: engine events win over write-one-to-clear
  always_comb begin
    flag_set         = '0;
    flag_set[F_INTR] = evt.ok;
    flag_set[F_DEV]  = evt.nack;
    flag_set[F_BUS]  = evt.arb;
    flag_set[F_FAIL] = evt.killed | evt.badproto;
    flag_clr         = sel_status ? host_wdata[FLAG_N:1] : '0;
    flag_d           = (flag_q & ~flag_clr) | flag_set;
    flag_en          = (|flag_set) | (|flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  // control: while busy only the kill bit is writable
  always_comb begin
    if (busy) begin
      ctrl_d                = ctrl_q;
      ctrl_d[CTRL_KILL_BIT] = host_wdata[CTRL_KILL_BIT];
    end else begin
      ctrl_d = host_wdata & CTRL_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (sel_ctrl) ctrl_q <= ctrl_d;
  end

  assign start_req = sel_ctrl && !busy && host_wdata[CTRL_START_BIT]
                     && !host_wdata[CTRL_KILL_BIT];
  assign start_bad = host_wdata[4];
  assign kill      = ctrl_q[CTRL_KILL_BIT];
  assign proto     = ctrl_q[4:2];
  assign flags     = flag_q;

  // command, address, data0, data1; the two data registers also capture reads
  for (genvar i = 0; i < NUM_BYTE_REGS; i++) begin : g_breg
    logic              sw_en, cap_en, en;
    logic [BYTE_W-1:0] d;
    assign sw_en = host_wr && (host_addr == ADDR_W'(OFS_BYTE0 + i));
    if (i == 2)      begin : g_c0 assign cap_en = cap0_en; end
    else if (i == 3) begin : g_c1 assign cap_en = cap1_en; end
    else             begin : g_nc assign cap_en = 1'b0;    end
    assign en = sw_en | cap_en;
    assign d  = cap_en ? cap_data : host_wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  breg_q[i] <= '0;
      else if (en) breg_q[i] <= d;
    end
  end

  assign cmd_q   = breg_q[0];
  assign addr_q  = breg_q[1];
  assign data0_q = breg_q[2];
  assign data1_q = breg_q[3];

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_STATUS)
      host_rdata = {{(BYTE_W-FLAG_N-1){1'b0}}, flag_q, busy};
    else if (host_addr == A_CTRL)
      host_rdata = ctrl_q;
    else
      for (int k = 0; k < NUM_BYTE_REGS; k++)
        if (host_addr == ADDR_W'(OFS_BYTE0 + k)) host_rdata = breg_q[k];
  end

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              start_bad,
  input  logic              kill,
  input  logic [2:0]        proto,
  input  logic [BYTE_W-1:0] cmd_q,
  input  logic [BYTE_W-1:0] addr_q,
  input  logic [BYTE_W-1:0] data0_q,
  input  logic [BYTE_W-1:0] data1_q,
  input  logic              op_done,
  input  logic              op_nack,
  input  logic              op_arb_lost,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic [BYTE_W-1:0] op_wdata,
  output logic              busy,
  output logic              abort_pend,
  output seq_evt_t          evt,
  output logic              cap0_en,
  output logic              cap1_en
);

  seq_state_e state_q, state_d;
  logic       err_q, err_d;
  logic       rd, two_phase, is_word;
  bus_op_e    code;

  assign rd        = addr_q[0];
  assign is_word   = (proto == 3'(PR_WORD));
  assign two_phase = (proto == 3'(PR_BDATA)) || is_word;

  // operation presented for the current state
  always_comb begin
    code     = OP_START;
    op_wdata = '0;
    unique case (state_q)
      SQ_ADDR: begin
        code     = OP_WRITE;
        op_wdata = two_phase ? {addr_q[BYTE_W-1:1], 1'b0} : addr_q;
      end
      SQ_CMD:   begin code = OP_WRITE; op_wdata = cmd_q; end
      SQ_ADDR2: begin code = OP_WRITE; op_wdata = {addr_q[BYTE_W-1:1], 1'b1}; end
      SQ_D0: begin
        code     = rd ? (is_word ? OP_RD_ACK : OP_RD_NACK) : OP_WRITE;
        op_wdata = data0_q;
      end
      SQ_D1: begin
        code     = rd ? OP_RD_NACK : OP_WRITE;
        op_wdata = data1_q;
      end
      SQ_STOP: code = OP_STOP;
      default: code = OP_START;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    evt     = '0;
    cap0_en = 1'b0;
    cap1_en = 1'b0;
    if (state_q == SQ_IDLE) begin
      if (start_req) begin
        if (start_bad) evt.badproto = 1'b1;
        else begin
          state_d = SQ_START;
          err_d   = 1'b0;
        end
      end
    end else if (kill) begin
      state_d    = SQ_IDLE;
      evt.killed = 1'b1;
    end else if (op_done) begin
      if (op_arb_lost) begin
        state_d = SQ_IDLE;
        evt.arb = 1'b1;
      end else if (code == OP_WRITE && op_nack) begin
        state_d = SQ_STOP;
        err_d   = 1'b1;
      end else begin
        unique case (state_q)
          SQ_START:  state_d = SQ_ADDR;
          SQ_ADDR: begin
            if (proto == 3'(PR_QUICK))     state_d = SQ_STOP;
            else if (proto == 3'(PR_BYTE)) state_d = rd ? SQ_D0 : SQ_CMD;
            else                           state_d = SQ_CMD;
          end
          SQ_CMD: begin
            if (proto == 3'(PR_BYTE)) state_d = SQ_STOP;
            else                      state_d = rd ? SQ_RSTART : SQ_D0;
          end
          SQ_RSTART: state_d = SQ_ADDR2;
          SQ_ADDR2:  state_d = SQ_D0;
          SQ_D0: begin
            cap0_en = rd;
            state_d = is_word ? SQ_D1 : SQ_STOP;
          end
          SQ_D1: begin
            cap1_en = rd;
            state_d = SQ_STOP;
          end
          SQ_STOP: begin
            state_d  = SQ_IDLE;
            evt.ok   = !err_q;
            evt.nack = err_q;
          end
          default: state_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign op_valid   = busy;
  assign op_code    = code;
  assign abort_pend = err_q;

endmodule

// File: rtl/smb_host.sv
module smb_host
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              irq,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic [7:0]        op_wdata,
  input  logic              op_done,
  input  logic              op_nack,
  input  logic              op_arb_lost,
  input  logic [7:0]        op_rdata
);

  logic              seq_busy, start_req, start_bad, ctrl_kill, abort_pend;
  logic              cap0_en, cap1_en;
  logic [2:0]        ctrl_proto;
  logic [BYTE_W-1:0] cmd_q, addr_q, data0_q, data1_q;
  logic [FLAG_N-1:0] st_flags;
  seq_evt_t          evt;

  smb_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .host_rdata,
    .busy(seq_busy), .evt, .cap0_en, .cap1_en, .cap_data(op_rdata),
    .start_req, .start_bad, .kill(ctrl_kill), .proto(ctrl_proto),
    .cmd_q, .addr_q, .data0_q, .data1_q, .flags(st_flags)
  );

  smb_host_seq u_seq (
    .clk, .rst_n, .start_req, .start_bad, .kill(ctrl_kill), .proto(ctrl_proto),
    .cmd_q, .addr_q, .data0_q, .data1_q,
    .op_done, .op_nack, .op_arb_lost,
    .op_valid, .op_code, .op_wdata,
    .busy(seq_busy), .abort_pend, .evt, .cap0_en, .cap1_en
  );

  assign irq = st_flags[F_INTR];

endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              kill,
  input logic              start_req,
  input logic              start_bad,
  input logic              abort_pend,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              op_done,
  input logic              op_nack,
  input logic              op_arb_lost,
  input logic              irq,
  input logic [FLAG_N-1:0] flags,
  input logic [2:0]        proto,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr
);

  logic fin;
  assign fin = op_valid && op_done && !kill;

  assert_kill_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kill) |=> (!busy && flags[F_FAIL]));

  assert_nack_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_code == 3'(OP_WRITE) && op_nack && !op_arb_lost)
      |=> (op_valid && op_code == 3'(OP_STOP)));

  assert_nack_noirq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_code == 3'(OP_STOP) && !op_arb_lost && abort_pend)
      |=> (!busy && flags[F_DEV] && !$rose(irq)));

  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_code == 3'(OP_STOP) && !op_arb_lost && !abort_pend)
      |=> (!busy && irq));

  assert_arb_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_arb_lost) |=> (!busy && flags[F_BUS]));

  assert_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !start_bad) |=> busy);

  assert_busy_keeps_proto_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && host_addr == ADDR_W'(OFS_CTRL)) |=> $stable(proto));

endmodule

bind smb_host smb_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk, .rst_n, .busy(seq_busy), .kill(ctrl_kill), .start_req, .start_bad,
  .abort_pend, .op_valid, .op_code, .op_done, .op_nack, .op_arb_lost,
  .irq, .flags(st_flags), .proto(ctrl_proto), .host_wr, .host_addr
);

// File: tb/smb_host_tb.sv
module smb_host_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          irq, op_valid;
  logic [2:0]    op_code;
  logic [7:0]    op_wdata;
  logic          op_done = 1'b0, op_nack = 1'b0, op_arb_lost = 1'b0;
  logic [7:0]    op_rdata = '0;

  smb_host #(.ADDR_W(AW)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [2:0] code; logic [7:0] data; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] rd_q[$];
  int n_chk = 0, n_err = 0;
  int lat = 2, cnt = 0, op_idx = 0, nack_at = -1, arb_at = -1;
  bit stall = 0, finished = 0;
  string cur_req = "R3";

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_op(logic [2:0] c, logic [7:0] d);
    exp_t e; e.code = c; e.data = d; exp_q.push_back(e);
  endtask

  // byte engine model and monitor
  always @(negedge clk) begin
    if (op_done) begin
      op_done = 0; op_nack = 0; op_arb_lost = 0; cnt = 0;
    end else if (op_valid && !stall) begin
      if (cnt >= lat) begin
        if (exp_q.size() == 0) chk(cur_req, {5'd0, op_code}, 8'hFF);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cur_req, {5'd0, op_code}, {5'd0, e.code});
          if (op_code == 3'd1) chk(cur_req, op_wdata, e.data);
        end
        op_nack     = (op_code == 3'd1) && (op_idx == nack_at);
        op_arb_lost = (op_idx == arb_at);
        if (op_code == 3'd2 || op_code == 3'd3)
          op_rdata = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hEE;
        op_done = 1;
        op_idx++;
      end else cnt++;
    end else cnt = 0;
  end

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic wait_idle(output logic [7:0] st);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #2; rd(0, st);
      if (!st[0]) return;
    end
  endtask

  task automatic setup(logic [7:0] a, logic [7:0] c, logic [7:0] d0, logic [7:0] d1);
    wr(3, c); wr(4, a); wr(5, d0); wr(6, d1);
    op_idx = 0;
  endtask

  logic [7:0] v, st;

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!finished) $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1", v, 8'h00);
    rd(2, v); chk("R1", v, 8'h00);
    rd(5, v); chk("R1", v, 8'h00);
    chk("R1", {6'd0, irq, op_valid}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R3 byte-data write
    cur_req = "R3";
    setup(8'hA0, 8'h12, 8'h34, 8'h00);
    expect_op(0, 0); expect_op(1, 8'hA0); expect_op(1, 8'h12); expect_op(1, 8'h34); expect_op(4, 0);
    wr(2, 8'h48);
    rd(0, v); chk("R13", v & 8'h01, 8'h01);
    wait_idle(st);
    chk("R6", st, 8'h02); chk("R6", {7'd0, irq}, 8'h01);
    chk("R3", 8'(exp_q.size()), 8'd0);
    // R2 readback map
    rd(2, v); chk("R2", v, 8'h08);
    rd(3, v); chk("R2", v, 8'h12);
    rd(4, v); chk("R2", v, 8'hA0);
    rd(6, v); chk("R2", v, 8'h00);
    rd(7, v); chk("R2", v, 8'h00);
    // R11 selective clear
    wr(0, 8'h05); rd(0, v); chk("R11", v, 8'h02);
    wr(0, 8'h02); rd(0, v); chk("R11", v, 8'h00); chk("R6", {7'd0, irq}, 8'h00);

    // R4 / R5 word read
    cur_req = "R4";
    setup(8'hA3, 8'h40, 8'h00, 8'h00);
    rd_q.push_back(8'h5A); rd_q.push_back(8'hC3);
    expect_op(0, 0); expect_op(1, 8'hA2); expect_op(1, 8'h40); expect_op(0, 0);
    expect_op(1, 8'hA3); expect_op(2, 0); expect_op(3, 0); expect_op(4, 0);
    wr(2, 8'h4C); wait_idle(st);
    chk("R4", st, 8'h02); chk("R4", 8'(exp_q.size()), 8'd0);
    rd(5, v); chk("R5", v, 8'h5A);
    rd(6, v); chk("R5", v, 8'hC3);
    wr(0, 8'h1E);

    // R4 / R5 byte-data read
    setup(8'hB1, 8'h07, 8'h00, 8'h00);
    rd_q.push_back(8'h66);
    expect_op(0, 0); expect_op(1, 8'hB0); expect_op(1, 8'h07); expect_op(0, 0);
    expect_op(1, 8'hB1); expect_op(3, 0); expect_op(4, 0);
    wr(2, 8'h48); wait_idle(st);
    chk("R4", 8'(exp_q.size()), 8'd0);
    rd(5, v); chk("R5", v, 8'h66);
    wr(0, 8'h1E);

    // R3 quick write
    cur_req = "R3";
    setup(8'h6C, 8'h00, 8'h00, 8'h00);
    expect_op(0, 0); expect_op(1, 8'h6C); expect_op(4, 0);
    wr(2, 8'h40); wait_idle(st);
    chk("R3", st, 8'h02); chk("R3", 8'(exp_q.size()), 8'd0);
    wr(0, 8'h1E);

    // R4 receive byte
    cur_req = "R4";
    setup(8'h91, 8'h00, 8'h00, 8'h00);
    rd_q.push_back(8'h7E);
    expect_op(0, 0); expect_op(1, 8'h91); expect_op(3, 0); expect_op(4, 0);
    wr(2, 8'h44); wait_idle(st);
    chk("R4", 8'(exp_q.size()), 8'd0);
    rd(5, v); chk("R5", v, 8'h7E);
    wr(0, 8'h1E);

    // R3 send byte and word write
    cur_req = "R3";
    setup(8'h90, 8'h3C, 8'h00, 8'h00);
    expect_op(0, 0); expect_op(1, 8'h90); expect_op(1, 8'h3C); expect_op(4, 0);
    wr(2, 8'h44); wait_idle(st);
    chk("R3", 8'(exp_q.size()), 8'd0);
    wr(0, 8'h1E);
    setup(8'h40, 8'h21, 8'hBE, 8'hEF);
    expect_op(0, 0); expect_op(1, 8'h40); expect_op(1, 8'h21);
    expect_op(1, 8'hBE); expect_op(1, 8'hEF); expect_op(4, 0);
    wr(2, 8'h4C); wait_idle(st);
    chk("R3", st, 8'h02); chk("R3", 8'(exp_q.size()), 8'd0);
    wr(0, 8'h1E);

    // R7 NACK on address
    cur_req = "R7";
    setup(8'hA0, 8'h12, 8'h34, 8'h00);
    nack_at = 1;
    expect_op(0, 0); expect_op(1, 8'hA0); expect_op(4, 0);
    wr(2, 8'h48); wait_idle(st);
    chk("R7", st, 8'h04); chk("R7", {7'd0, irq}, 8'h00);
    chk("R7", 8'(exp_q.size()), 8'd0);
    nack_at = -1;
    wr(0, 8'h1E);

    // R8 lost arbitration on the command byte
    cur_req = "R8";
    setup(8'hA0, 8'h12, 8'h34, 8'h00);
    arb_at = 2;
    expect_op(0, 0); expect_op(1, 8'hA0); expect_op(1, 8'h12);
    wr(2, 8'h48); wait_idle(st);
    chk("R8", st, 8'h08); chk("R8", {7'd0, irq}, 8'h00);
    chk("R8", 8'(exp_q.size()), 8'd0);
    repeat (4) @(negedge clk);
    chk("R8", {7'd0, op_valid}, 8'h00);
    arb_at = -1;
    wr(0, 8'h1E);

    // R9 kill
    cur_req = "R9";
    stall = 1;
    setup(8'hA0, 8'h12, 8'h34, 8'h00);
    wr(2, 8'h48);
    repeat (3) @(negedge clk);
    wr(2, 8'h0A);
    rd(0, v); chk("R9", v & 8'h01, 8'h01);
    @(negedge clk); #2;
    rd(0, v); chk("R9", v, 8'h10);
    exp_q.delete();
    stall = 0;
    wr(2, 8'h08);
    wr(0, 8'h1E);

    // R10 start while busy
    cur_req = "R10";
    stall = 1;
    setup(8'hA0, 8'h12, 8'h34, 8'h00);
    expect_op(0, 0); expect_op(1, 8'hA0); expect_op(1, 8'h12); expect_op(1, 8'h34); expect_op(4, 0);
    wr(2, 8'h48);
    wr(2, 8'h4C);
    rd(2, v); chk("R10", v, 8'h08);
    stall = 0;
    wait_idle(st);
    chk("R10", 8'(exp_q.size()), 8'd0);
    repeat (5) @(negedge clk);
    chk("R10", {7'd0, op_valid}, 8'h00);
    wr(0, 8'h1E);

    // R12 unsupported protocol
    cur_req = "R12";
    wr(2, 8'h54);
    repeat (5) @(negedge clk);
    rd(0, v); chk("R12", v, 8'h10);
    chk("R12", {7'd0, op_valid}, 8'h00);
    // R11 write to busy bit has no effect, clear leaves others
    wr(0, 8'h01); rd(0, v); chk("R11", v, 8'h10);
    wr(0, 8'h10); rd(0, v); chk("R11", v, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule